// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Scheduler

This block decides, once per timeslot, which inputs of an N-port crossbar connect to which outputs. Each input keeps a separate queue for every output. The caller presents a flattened N×N request matrix and pulses `start_i`. Bit `i*N+j` set means input i has traffic waiting for output j.

The scheduler then runs up to `ITERS` matching rounds, one per clock. Each round has three steps:

- Every still-free output grants one of the free inputs that request it. The choice is round-robin, starting from that output's grant pointer.
- Every input that received grants accepts one of them. The choice is round-robin, starting from that input's accept pointer.
- Each accepted pair is added to the match and frozen there.

Rounds stop early when a round adds nothing. The block then raises `done_o` for one cycle and holds the match on `match_o` until the next accepted start.

Pointers advance only on pairs made in the first round. An output's grant pointer moves to the input just past the one that accepted it. An input's accept pointer moves to the output just past the one it accepted. This spreads service fairly between competing ports over successive timeslots.

Top module: `rr_xbar_sched`

## Requirements
- R1: After reset, `match_o` is all zero and `done_o` and `busy_o` are low. All grant and accept pointers point at index 0.
- R2: In `match_o`, bit i*N+j means input i is connected to output j. Each input has at most one bit set, and each output has at most one bit set.
- R3: Every set bit of `match_o` at `done_o` was set in the request matrix captured at the accepted start.
- R4: With `ITERS` at least N, the final match is maximal. No requested pair has both its input and its output unmatched.
- R5: Round-robin order holds. From reset, an all-ones request gives the identity match (input k to output k).
- R6: Pointers change only on first-round pairs. With the default N=4, a second all-ones request right after R5's gives input 0 to output 1, input 1 to output 0, input 2 to output 2 and input 3 to output 3.
- R7: One round takes one clock. Say the start is taken at edge s and the last round runs at edge s+k. Then `done_o` is high in the cycle after edge s+k, and `busy_o` is low at that time. The value k is the first round that adds no pair, or `ITERS`, whichever comes first. An empty request gives k=1. A single request gives k=2.
- R8: `done_o` is a one-cycle pulse. While idle and with no start, `match_o` stays unchanged.
- R9: A `start_i` pulse while `busy_o` is high is ignored.
- R10: The request matrix is sampled only at the accepted start. Later changes on `req_i` during the rounds have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a schedule; taken only while idle |
| req_i | input | N*N | Request matrix, bit i*N+j = input i wants output j |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse: match complete |
| match_o | output | N*N | Match matrix, same bit layout as the requests |

## Verification
Directed patterns separate the pointer behaviour:
- An empty matrix and a single request pin the early-stop round count exactly.
- Two back-to-back all-ones matrices from reset give two different, fully predictable permutations. These separate correct first-round pointer updates from pointers that never move or that move in every round.
- A start pulse and garbage on `req_i` during a run show that the captured matrix alone decides the result.

Several hundred random matrices of varying density then check:
- that the match has at most one bit per row and per column;
- that every matched pair was requested;
- that the match is maximal;
- that the round count stays within bound.

// File: rtl/rrx_pkg.sv
package rrx_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} rrx_state_e;
endpackage

// File: rtl/rrx_pick.sv
// Round-robin one-hot pick: first set candidate at or after ptr_i, wrapping.
module rrx_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  cand_i,
  input  logic [PW-1:0] ptr_i,
  output logic [N-1:0]  pick_o
);
  logic found;
  always_comb begin
    pick_o = '0;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_i) + k;
      if (idx >= N) idx = idx - N;
      if (!found && cand_i[idx]) begin
        pick_o[idx] = 1'b1;
        found       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rrx_ptr.sv
// Rotating pointer: on update, moves to one past the selected index.
module rrx_ptr #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  logic [N-1:0]  sel_i,
  output logic [PW-1:0] ptr_o
);
  logic [PW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_o;
    for (int k = 0; k < N; k++) begin
      if (sel_i[k]) ptr_d = (k == N-1) ? '0 : PW'(k + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_o <= '0;
    else if (upd_i) ptr_o <= ptr_d;
  end
endmodule

// File: rtl/rr_xbar_sched.sv
module rr_xbar_sched
  import rrx_pkg::*;
#(
  parameter int N     = 4,
  parameter int ITERS = N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N*N-1:0] req_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N*N-1:0] match_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [IW-1:0] LAST = IW'(ITERS - 1);

  rrx_state_e st_q, st_d;
  logic [IW-1:0] iter_q, iter_d;
  logic [N-1:0][N-1:0] req_q, mt_q, mt_d;
  logic done_d, load, first;
  logic [N-1:0] in_free, out_free;
  logic [N-1:0][N-1:0] gcand;   // [output][input]
  logic [N-1:0][N-1:0] gnt;     // [output][input]
  logic [N-1:0][N-1:0] acand;   // [input][output]
  logic [N-1:0][N-1:0] acc;     // [input][output]
  logic [N-1:0][N-1:0] acc_t;   // [output][input]
  logic [N-1:0][PW-1:0] gptr, aptr;
  logic any_new;

  // free ports and grant candidates
  always_comb begin
    for (int i = 0; i < N; i++) in_free[i] = ~|mt_q[i];
    for (int j = 0; j < N; j++) begin
      out_free[j] = 1'b1;
      for (int i = 0; i < N; i++) if (mt_q[i][j]) out_free[j] = 1'b0;
    end
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        gcand[j][i] = req_q[i][j] & in_free[i] & out_free[j];
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        acand[i][j] = gnt[j][i];
        acc_t[j][i] = acc[i][j];
      end
  end

  assign any_new = |acc;
  assign first   = (st_q == ST_RUN) && (iter_q == '0);

  for (genvar g = 0; g < N; g++) begin : g_port
    rrx_pick #(.N(N), .PW(PW)) u_grant (
      .cand_i(gcand[g]), .ptr_i(gptr[g]), .pick_o(gnt[g]));
    rrx_pick #(.N(N), .PW(PW)) u_accept (
      .cand_i(acand[g]), .ptr_i(aptr[g]), .pick_o(acc[g]));
    rrx_ptr #(.N(N), .PW(PW)) u_gptr (
      .clk(clk), .rst_n(rst_n), .upd_i(first && |acc_t[g]),
      .sel_i(acc_t[g]), .ptr_o(gptr[g]));
    rrx_ptr #(.N(N), .PW(PW)) u_aptr (
      .clk(clk), .rst_n(rst_n), .upd_i(first && |acc[g]),
      .sel_i(acc[g]), .ptr_o(aptr[g]));
  end

  // next state
  always_comb begin
    st_d   = st_q;
    iter_d = iter_q;
    mt_d   = mt_q;
    done_d = 1'b0;
    load   = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_RUN;
        iter_d = '0;
        mt_d   = '0;
        load   = 1'b1;
      end
      ST_RUN: begin
        mt_d   = mt_q | acc;
        iter_d = iter_q + IW'(1);
        if (!any_new || iter_q == LAST) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      iter_q <= '0;
      mt_q   <= '0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      iter_q <= iter_d;
      mt_q   <= mt_d;
      done_o <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    req_q <= '0;
    else if (load) req_q <= req_i;
  end

  assign busy_o  = (st_q == ST_RUN);
  assign match_o = mt_q;
endmodule

// File: rtl/rr_xbar_sched_chk.sv
module rr_xbar_sched_chk #(
  parameter int N     = 4,
  parameter int ITERS = N
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [N*N-1:0] req_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [N*N-1:0] match_o
);
  logic [N*N-1:0] cap;
  logic [N-1:0]   rfree, cfree;
  logic           viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cap <= '0;
    else if (start_i && !busy_o) cap <= req_i;
  end

  always_comb begin
    for (int i = 0; i < N; i++) rfree[i] = ~|match_o[i*N +: N];
    for (int j = 0; j < N; j++) begin
      cfree[j] = 1'b1;
      for (int i = 0; i < N; i++) if (match_o[i*N+j]) cfree[j] = 1'b0;
    end
    viol = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (cap[i*N+j] && rfree[i] && cfree[j]) viol = 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [N-1:0] col;
    always_comb for (int i = 0; i < N; i++) col[i] = match_o[i*N+g];
    a_r2_row_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_o[g*N +: N]));
    a_r2_col_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

  a_r3_requested_only: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((match_o & ~cap) == '0));

  if (ITERS >= N) begin : g_max
    a_r4_maximal: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !viol);
  end

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_match_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(match_o));
endmodule

bind rr_xbar_sched rr_xbar_sched_chk #(.N(N), .ITERS(ITERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
  .busy_o(busy_o), .done_o(done_o), .match_o(match_o));

// File: tb/test_rr_xbar_sched.sv
`timescale 1ns/1ps
module test_rr_xbar_sched;
  localparam int N  = 4;
  localparam int IT = 4;
  localparam int NN = N*N;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [NN-1:0] req;
  logic busy, done;
  logic [NN-1:0] match;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rr_xbar_sched #(.N(N), .ITERS(IT)) i_rr_xbar_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start), .req_i(req),
    .busy_o(busy), .done_o(done), .match_o(match));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit f_unique(input logic [NN-1:0] m);
    for (int i = 0; i < N; i++) begin
      int rc = 0;
      int cc = 0;
      for (int j = 0; j < N; j++) begin
        rc += m[i*N+j];
        cc += m[j*N+i];
      end
      if (rc > 1 || cc > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit f_maximal(input logic [NN-1:0] m, input logic [NN-1:0] r);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        bit rf = 1'b1;
        bit cf = 1'b1;
        for (int k = 0; k < N; k++) begin
          if (m[i*N+k]) rf = 1'b0;
          if (m[k*N+j]) cf = 1'b0;
        end
        if (r[i*N+j] && rf && cf) return 1'b0;
      end
    return 1'b1;
  endfunction

  task automatic run(input logic [NN-1:0] r, input bit poke,
                     output logic [NN-1:0] m, output int lat);
    @(negedge clk); start = 1'b1; req = r;
    @(negedge clk); start = 1'b0; req = NN'($urandom); lat = 1;  // R10 garbage
    if (poke) begin start = 1'b1; req = '0; end                  // R9 ignored
    while (!done && lat < 40) begin
      @(negedge clk); start = 1'b0; req = NN'($urandom); lat++;
    end
    chk(done, "R7 done seen", {31'b0, done}, 32'd1);
    m = match;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [NN-1:0] m, r, hold;
    int lat;
    void'($urandom(32'd2025));
    rst_n = 1'b0; start = 1'b0; req = '0;
    repeat (3) @(negedge clk);
    chk(match == '0 && !done && !busy, "R1 reset state", {match, 14'b0, busy, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run('0, 1'b0, m, lat);
    chk(m == '0, "R3 empty request", m, 32'd0);
    chk(lat == 2, "R7 empty latency", lat, 2);

    run('1, 1'b0, m, lat);
    chk(m == 16'h8421, "R5 identity from reset", m, 32'h8421);
    chk(lat == IT + 1, "R7 full latency", lat, IT + 1);

    run('1, 1'b1, m, lat);
    chk(m == 16'h8412, "R6 first-round pointer move / R9 R10", m, 32'h8412);

    run(16'h0800, 1'b0, m, lat);
    chk(m == 16'h0800, "R3 single request", m, 32'h0800);
    chk(lat == 3, "R7 single latency", lat, 3);

    @(negedge clk);
    chk(!done, "R8 done pulse width", {31'b0, done}, 32'd0);
    hold = match;
    repeat (3) @(negedge clk);
    chk(match == hold, "R8 match held", match, hold);

    for (int t = 0; t < 300; t++) begin
      case (t % 3)
        0: r = NN'($urandom) & NN'($urandom);
        1: r = NN'($urandom);
        default: r = NN'($urandom) | NN'($urandom);
      endcase
      run(r, (t % 5) == 0, m, lat);
      chk(f_unique(m), "R2 one per port", m, 32'd0);
      chk((m & ~r) == '0, "R3 requested", m, r);
      chk(f_maximal(m, r), "R4 maximal", m, r);
      chk(lat >= 2 && lat <= IT + 1, "R7 latency bound", lat, IT + 1);
    end
    finish_run();
  end
endmodule